// File: doc/BRIEF.md
# Register-Configuration Bus Master Controller

This block is the master side of a small control bus that a local requester uses to read and write configuration registers in a set of slaves. There is one master on the bus, so no arbitration stage is needed. A request is accepted from a local port. The block then places a single-cycle command on the bus, consisting of the enable, the direction and the address. It waits for the addressed slave to raise its valid handshake and then moves exactly one data word over a shared bidirectional data bus. Bursts are not supported.

While the block waits for the handshake, a response timer runs. If the slave stays silent for the full timeout window, the attempt counts as failed. A policy input then chooses what happens next. With the policy set, the command is reissued, up to a parameterised number of retries. With the policy clear, or once the retries are used up, the transfer is discarded and completes with an error response. The address is forwarded as given; any address encoding is handled by the requester.

Top module: `cfgbus_master`

## Requirements
- R1: Straight after reset the block shows req_ready=1, rsp_valid=0 and bus_en=0.
- R2: Call the clock edge that samples req_valid while req_ready=1 edge E0. From E0, bus_en is high for exactly one cycle. In that cycle bus_dir is the requested direction (1 = write, 0 = read) and bus_addr is the requested address.
- R3: After the command cycle, the block watches slv_vld in each wait cycle. If slv_vld is high in wait cycle d (counting from 0), the single data cycle follows. rsp_valid is then high for exactly one cycle, starting at edge E0+3+d.
- R4: For a write, the block drives bus_data with the write word only in the data cycle. It drives bus_data only in a cycle that directly follows a slv_vld pulse.
- R5: For a read, rsp_rdata returns the word the slave placed on bus_data during the data cycle, and rsp_error=0.
- R6: The wait lasts at most TIMEOUT cycles. If slv_vld arrives in wait cycle TIMEOUT-1, the transfer still succeeds. If slv_vld is never seen in the window, the attempt fails and one error cycle follows.
- R7: In the error cycle, if retry_en=1 and fewer than MAX_RETRY reissues have been made, a new one-cycle command with the same fields follows directly. Each failed attempt therefore takes TIMEOUT+2 cycles.
- R8: If retry_en=0 in the error cycle, or the reissues are used up, the transfer completes with rsp_valid=1 and rsp_error=1. This gives a total of 1 command attempt, or MAX_RETRY+1 attempts, respectively.
- R9: With each response, rsp_retries gives the number of reissued commands that the transfer needed.
- R10: req_ready is low from E0 until the cycle in which the response is shown. A req_valid held high during that time starts no new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write word |
| retry_en | input | 1 | Policy: 1 = reissue a timed-out command, 0 = discard it |
| req_ready | output | 1 | Idle; a request is taken this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion was a discard after a timeout |
| rsp_rdata | output | DW | Read word |
| rsp_retries | output | RW | Number of reissued commands |
| bus_en | output | 1 | Command-phase enable |
| bus_dir | output | 1 | Command direction |
| bus_addr | output | AW | Command address |
| bus_data | inout | DW | Shared write/read data |
| slv_vld | input | 1 | Slave handshake |

## Verification
The bench targets the boundaries of the wait window. A slave that answers in the last allowed wait cycle must still succeed; an off-by-one timer would instead report an error there. It also counts reissued commands: a slave that ignores exactly MAX_RETRY attempts must still succeed, and one that ignores more must produce a discard after MAX_RETRY+1 commands. An error in the retry cap shows up as a wrong command count or a false error. The bench further compares response latency cycle by cycle, checks that a held req_valid does not start a second transfer, and checks write data as captured at the slave. A design that mistimes the data cycle or drives the bus in the wrong cycle returns wrong data.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_ERR  = 3'd4
  } cfg_state_e;
endpackage

// File: rtl/cfgbus_timer.sv
module cfgbus_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  // R6: wait counter never passes the window
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/cfgbus_retry.sv
module cfgbus_retry #(
  parameter int MAX_RETRY = 3,
  localparam int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic          can_retry,
  output logic [RW-1:0] count
);
  localparam logic [RW-1:0] CAP = RW'(MAX_RETRY);

  logic [RW-1:0] cnt_q;

  assign count     = cnt_q;
  assign can_retry = (cnt_q < CAP);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc && can_retry) cnt_q <= cnt_q + 1'b1;
  end

  // R7: reissue count capped
  a_r7_retry_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);
endmodule

// File: rtl/cfgbus_datapath.sv
module cfgbus_datapath #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          ld_write,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (load) begin
        cmd_write <= ld_write;
        cmd_addr  <= ld_addr;
        cmd_wdata <= ld_wdata;
      end
      if (capture) rdata <= bus_in;
    end
  end
endmodule

// File: rtl/cfgbus_master.sv
module cfgbus_master
  import cfgbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int TIMEOUT   = 16,
  parameter int MAX_RETRY = 3,
  localparam int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          retry_en,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [RW-1:0] rsp_retries,
  output logic          bus_en,
  output logic          bus_dir,
  output logic [AW-1:0] bus_addr,
  inout  wire  [DW-1:0] bus_data,
  input  logic          slv_vld
);
  cfg_state_e state_q, state_d;
  logic accept, expired, can_retry, reissue, finish;
  logic en_q, oe_q, rsp_valid_q, rsp_error_q;
  logic cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rdata;
  logic [RW-1:0] retries;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign reissue = (state_q == ST_ERR) && retry_en && can_retry;
  assign finish  = (state_q == ST_DATA) || ((state_q == ST_ERR) && !reissue);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_CMD;
      ST_CMD:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (slv_vld) state_d = ST_DATA;
        else if (expired) state_d = ST_ERR;
      end
      ST_DATA: state_d = ST_IDLE;
      ST_ERR:  state_d = reissue ? ST_CMD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      en_q        <= 1'b0;
      oe_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_error_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      en_q        <= (state_d == ST_CMD);
      oe_q        <= (state_d == ST_DATA) && cmd_write;
      rsp_valid_q <= finish;
      if (finish) rsp_error_q <= (state_q == ST_ERR);
    end
  end

  cfgbus_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_WAIT), .expired(expired)
  );

  cfgbus_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst(rst), .clr(accept), .inc(reissue),
    .can_retry(can_retry), .count(retries)
  );

  cfgbus_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .load(accept), .ld_write(req_write),
    .ld_addr(req_addr), .ld_wdata(req_wdata),
    .capture((state_q == ST_DATA) && !cmd_write), .bus_in(bus_data),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rdata(rdata)
  );

  assign bus_data    = oe_q ? cmd_wdata : 'z;
  assign bus_en      = en_q;
  assign bus_dir     = cmd_write;
  assign bus_addr    = cmd_addr;
  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_error   = rsp_error_q;
  assign rsp_rdata   = rdata;
  assign rsp_retries = retries;

  // R2: command phase is a single cycle
  a_r2_cmd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> !bus_en);
  // R4: bus driven only right after a slave handshake
  a_r4_drive_after_vld: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(slv_vld));
  // R3: completion is a one-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R8: an error means discard policy or cap reached
  a_r8_error_cause: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_error) |-> (!$past(retry_en) || rsp_retries == RW'(MAX_RETRY)));
  // R10: no command issued while a response is shown idle
  a_r10_no_cmd_when_ready: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_en);
endmodule

// File: tb/cfgbus_master_bench.sv
module cfgbus_master_bench;
  localparam int AW = 16, DW = 32, TO = 8, MR = 3;
  localparam int RW = $clog2(MR + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, retry_en = 0, slv_vld = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_error, bus_en, bus_dir;
  logic [DW-1:0] rsp_rdata;
  logic [RW-1:0] rsp_retries;
  logic [AW-1:0] bus_addr;
  wire  [DW-1:0] bus_data;

  // slave model state
  logic s_drive = 0;
  logic [DW-1:0] s_rdata = '0, s_wcap = '0;
  int s_delay = 0, s_ignore = 0, s_cmds = 0, s_bad_fields = 0;
  logic [AW-1:0] s_exp_addr = '0;
  logic s_exp_dir = 0;

  int checks = 0, failures = 0;

  assign bus_data = s_drive ? s_rdata : 'z;

  always #2 clk = ~clk;

  cfgbus_master #(.AW(AW), .DW(DW), .TIMEOUT(TO), .MAX_RETRY(MR)) u_cfgbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .retry_en(retry_en),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .rsp_retries(rsp_retries), .bus_en(bus_en),
    .bus_dir(bus_dir), .bus_addr(bus_addr), .bus_data(bus_data), .slv_vld(slv_vld)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave: counts commands, checks fields, answers after s_ignore ignored attempts
  initial begin
    forever begin
      @(negedge clk);
      if (bus_en) begin
        s_cmds++;
        if (bus_addr !== s_exp_addr || bus_dir !== s_exp_dir) s_bad_fields++;
        if (s_ignore > 0) s_ignore--;
        else begin
          repeat (s_delay + 1) @(negedge clk);
          slv_vld = 1'b1;
          @(negedge clk);
          slv_vld = 1'b0;
          if (s_exp_dir) s_wcap = bus_data;
          else s_drive = 1'b1;
          @(negedge clk);
          s_drive = 1'b0;
        end
      end
    end
  end

  function automatic int exp_attempts(int ign, logic pol);
    int allowed = pol ? MR : 0;
    return (ign > allowed) ? allowed + 1 : ign + 1;
  endfunction

  function automatic int exp_latency(int ign, int d, logic pol);
    int att = exp_attempts(ign, pol);
    if (ign >= att) return att * (TO + 2) + 1;
    return ign * (TO + 2) + 4 + d;
  endfunction

  task automatic run_txn(logic wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                         logic [DW-1:0] rd, int d, int ign, logic pol, logic hold);
    int att = exp_attempts(ign, pol);
    logic err = (ign >= att);
    int lat = 0;
    int extra = 0;
    s_delay = d; s_ignore = ign; s_cmds = 0; s_bad_fields = 0;
    s_exp_addr = a; s_exp_dir = wr; s_rdata = rd; s_wcap = '0;
    retry_en = pol;
    req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    if (!hold) req_valid = 1'b0;
    check("R10 ready low after accept", {63'd0, req_ready}, 64'd0);
    while (!rsp_valid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check("R3/R6/R7 response latency", 64'(lat), 64'(exp_latency(ign, d, pol)));
    check("R8 error flag", {63'd0, rsp_error}, {63'd0, err});
    check("R8 command attempts", 64'(s_cmds), 64'(att));
    check("R9 retries", 64'(rsp_retries), 64'(att - 1));
    check("R2 command fields", 64'(s_bad_fields), 64'd0);
    if (!err && wr) check("R4 write data at slave", 64'(s_wcap), 64'(wd));
    if (!err && !wr) check("R5 read data", 64'(rsp_rdata), 64'(rd));
    @(negedge clk);
    check("R3 response one cycle", {63'd0, rsp_valid}, 64'd0);
    if (hold) begin
      // R10: held request must not have started a second command
      repeat (3) begin
        @(negedge clk);
        if (bus_en) extra++;
      end
      check("R10 held request ignored", 64'(extra), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {63'd0, req_ready}, 64'd1);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R1 bus_en after reset", {63'd0, bus_en}, 64'd0);
    // directed corners
    run_txn(1'b1, 16'hF000, 32'hDEAD_BEEF, '0, 0, 0, 1'b0, 1'b0);        // R4 write, no wait
    run_txn(1'b0, 16'hFF18, '0, 32'h1234_5678, TO - 1, 0, 1'b0, 1'b0);   // R6 last wait cycle
    run_txn(1'b0, 16'h0FFC, '0, 32'hA5A5_0000, 2, 1, 1'b0, 1'b0);        // R8 discard, no retry
    run_txn(1'b1, 16'h1000, 32'h0000_0200, '0, 1, 2, 1'b1, 1'b0);        // R7 retry then ok
    run_txn(1'b0, 16'h2004, '0, 32'h0BAD_F00D, 0, MR, 1'b1, 1'b0);       // R7 exactly at cap
    run_txn(1'b1, 16'h3008, 32'h5555_AAAA, '0, 0, MR + 1, 1'b1, 1'b0);   // R8 cap exhausted
    run_txn(1'b1, 16'h400C, 32'h0F0F_F0F0, '0, 3, 0, 1'b0, 1'b1);        // R10 held req_valid
    // constrained random
    for (int i = 0; i < 40; i++) begin
      run_txn(1'($urandom), 16'($urandom) & 16'hFFFC, $urandom, $urandom,
              int'($urandom % TO), int'($urandom % (MR + 2)), 1'($urandom), 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule